// File: doc/BRIEF.md
# Flag-Producing Integer Shift Unit

This block is the purely combinational shifter of an x86-like integer datapath. In one evaluation it takes an operation code, an operand size, a value, a raw shift count and the current arithmetic flag word. It returns the shifted value and the flag word that the core commits after the instruction. Three shifts are supported: left shift, logical right shift and arithmetic right shift. They work on byte, half-word or word operands held in the low bits of a 32-bit bus.

The raw count is reduced to five bits before use. A reduced count of zero makes the instruction a no-op for the flags. The carry output is the last bit that leaves the operand. The overflow flag is defined only for single-bit shifts and holds its old value otherwise. The auxiliary flag is forced high on every real shift, and parity is taken over the low result byte only. Any register stage for the result or the flags belongs to the surrounding pipeline.

Top module: `shift_flag_unit`

## Requirements
- R1: Only bits [4:0] of the 8-bit `shift_cnt` are used. Raw counts that agree in those five bits give identical outputs, for every operand size.
- R2: When the reduced count is zero, `result` equals `operand` restricted to the selected width, and `flags_out` equals `flags_in` bit for bit.
- R3: `op_sel` 0 shifts left with zero fill, 1 shifts right with zero fill, and 2 shifts right filling with the operand's top bit at the selected width. `size_sel` 0, 1 and 2 select 8, 16 and 32 bits. `result` bits above the selected width are always 0. Counts past the width give 0 for the logical shifts and all sign bits for the arithmetic shift.
- R4: On a nonzero count, CF (flag bit 0) is the last bit shifted out. That is bit n-1 of the operand for a right shift by n and bit (width-n) for a left shift by n. Past the width it is 0 for the logical shifts and the sign bit for the arithmetic shift.
- R5: When the reduced count is exactly 1, OF (flag bit 11) is set as follows. For an arithmetic right shift it is 0. For a logical right shift it is the operand's top bit at the selected width. For a left shift it is the XOR of the operand's two top bits at that width.
- R6: When the reduced count is 2 or more, OF (flag bit 11) equals its input value.
- R7: On a nonzero count, ZF (flag bit 6) is 1 exactly when the sized result is zero, and SF (flag bit 7) is the result's top bit at the selected width.
- R8: On a nonzero count, PF (flag bit 2) is 1 when `result[7:0]` holds an even number of ones, whatever the size.
- R9: On a nonzero count, AF (flag bit 4) is 1.
- R10: Flag bits 1, 3, 5, 8, 9 and 10 of `flags_out` always equal the same bits of `flags_in`.
- R11: `op_sel` 3 behaves exactly like a left shift (code 0), and `size_sel` 3 behaves exactly like the 32-bit size (code 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 left |
| size_sel | input | 2 | Operand size: 0 byte, 1 half-word, 2 or 3 word |
| operand | input | 32 | Value to shift, low bits used at smaller sizes |
| shift_cnt | input | 8 | Raw shift count, low five bits used |
| flags_in | input | 12 | Current flag word (CF 0, PF 2, AF 4, ZF 6, SF 7, OF 11) |
| result | output | 32 | Shifted value, zero above the selected width |
| flags_out | output | 12 | Updated flag word |

## Verification
The block holds no state, so a wrong internal value shows on `result` or `flags_out` in the same evaluation that produced it. A lane that picks up fill bits at the wrong boundary shows as corrupt high result bits, or as a wrong CF once the count passes the width. A bad count-of-one decode shows on OF, either at a count of one or in the OF hold at larger counts. The bench compares every port against a bit-serial model on each clock. It sweeps all operation and size codes over counts chosen around 0, 1, the lane widths and the mask boundary.

// File: rtl/shu_pkg.sv
package shu_pkg;

   typedef enum logic [1:0] {
      SHU_LEFT    = 2'd0,
      SHU_RIGHT_L = 2'd1,
      SHU_RIGHT_A = 2'd2,
      SHU_LEFT_B  = 2'd3
   } shu_op_e;

   localparam int SHU_FLAG_W = 12;
   localparam int FL_CARRY   = 0;
   localparam int FL_PARITY  = 2;
   localparam int FL_AUX     = 4;
   localparam int FL_ZERO    = 6;
   localparam int FL_SIGN    = 7;
   localparam int FL_OVF     = 11;

   localparam logic [SHU_FLAG_W-1:0] SHU_OWNED_MASK =
      SHU_FLAG_W'((1 << FL_CARRY) | (1 << FL_PARITY) | (1 << FL_AUX) |
                  (1 << FL_ZERO)  | (1 << FL_SIGN)   | (1 << FL_OVF));

   localparam int SHU_NUM_LANES = 3;

   typedef struct packed {
      logic cy;        // last bit shifted out
      logic src_top;   // operand top bit at lane width
      logic src_next;  // operand bit just below the top
      logic res_top;   // result top bit at lane width
   } shu_lane_info_t;

   function automatic int lane_width(input int idx);
      return 8 << idx;
   endfunction

   function automatic logic is_right(input shu_op_e op);
      return (op == SHU_RIGHT_L) || (op == SHU_RIGHT_A);
   endfunction

endpackage

// File: rtl/shu_count_mask.sv
module shu_count_mask #(
   parameter int CNT_IN_W = 8,
   parameter int CNT_BITS = 5
) (
   input  logic [CNT_IN_W-1:0] cnt_raw,
   output logic [CNT_BITS-1:0] cnt_eff,
   output logic                cnt_zero,
   output logic                cnt_one
);

   localparam logic [CNT_BITS-1:0] ONE = CNT_BITS'(1);

   if (CNT_IN_W < CNT_BITS) begin : g_bad_width
      $error("shu_count_mask: raw count narrower than masked count");
   end

   always_comb begin
      cnt_eff  = cnt_raw[CNT_BITS-1:0];
      cnt_zero = (cnt_eff == '0);
      cnt_one  = (cnt_eff == ONE);
   end

endmodule

// File: rtl/shu_lane.sv
module shu_lane
   import shu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int LANE_W   = 8,
   parameter int CNT_BITS = 5
) (
   input  shu_op_e             op,
   input  logic [DATA_W-1:0]   src,
   input  logic [CNT_BITS-1:0] cnt,
   output logic [DATA_W-1:0]   res,
   output shu_lane_info_t      info
);

   localparam int WIDE_R = 2*DATA_W + 1;
   localparam int WIDE_L = 2*DATA_W;
   localparam logic [DATA_W-1:0] LANE_MASK = {DATA_W{1'b1}} >> (DATA_W - LANE_W);

   if (LANE_W > DATA_W || LANE_W < 2) begin : g_bad_lane
      $error("shu_lane: lane width out of range");
   end
   if ((1 << CNT_BITS) > DATA_W) begin : g_bad_cnt
      $error("shu_lane: count range exceeds datapath width");
   end

   logic              fill;
   logic [DATA_W-1:0] ext;
   logic [WIDE_R-1:0] rvec;
   logic [WIDE_L-1:0] lvec;
   logic [DATA_W-1:0] sel;
   logic              cy_r, cy_l;

   // sign or zero extension of the lane operand up to the datapath
   always_comb begin
      fill = (op == SHU_RIGHT_A) & src[LANE_W-1];
      for (int b = 0; b < DATA_W; b++) begin
         ext[b] = (b < LANE_W) ? src[b] : fill;
      end
   end

   // right shift: one guard bit below the value catches the carry
   always_comb begin
      rvec = {{DATA_W{fill}}, ext, 1'b0} >> cnt;
      cy_r = rvec[0];
   end

   // left shift: carry sits just above the lane after the shift
   always_comb begin
      lvec = {{DATA_W{1'b0}}, ext} << cnt;
      cy_l = lvec[LANE_W];
   end

   always_comb begin
      sel           = is_right(op) ? rvec[DATA_W:1] : lvec[DATA_W-1:0];
      res           = sel & LANE_MASK;
      info.cy       = is_right(op) ? cy_r : cy_l;
      info.src_top  = src[LANE_W-1];
      info.src_next = src[LANE_W-2];
      info.res_top  = sel[LANE_W-1];
   end

endmodule

// File: rtl/shu_flag_gen.sv
module shu_flag_gen
   import shu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  shu_op_e               op,
   input  logic [DATA_W-1:0]     res,
   input  shu_lane_info_t        info,
   input  logic                  cnt_zero,
   input  logic                  cnt_one,
   input  logic [SHU_FLAG_W-1:0] flags_in,
   output logic [SHU_FLAG_W-1:0] flags_out
);

   logic ovf_one;

   always_comb begin
      unique case (op)
         SHU_RIGHT_A: ovf_one = 1'b0;
         SHU_RIGHT_L: ovf_one = info.src_top;
         default:     ovf_one = info.src_top ^ info.src_next;
      endcase
   end

   always_comb begin
      flags_out = flags_in;
      if (!cnt_zero) begin
         flags_out[FL_CARRY]  = info.cy;
         flags_out[FL_AUX]    = 1'b1;
         flags_out[FL_ZERO]   = (res == '0);
         flags_out[FL_SIGN]   = info.res_top;
         flags_out[FL_PARITY] = ~^res[7:0];
         if (cnt_one) begin
            flags_out[FL_OVF] = ovf_one;
         end
      end
   end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
   import shu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_IN_W = 8,
   parameter int CNT_BITS = 5
) (
   input  logic [1:0]            op_sel,
   input  logic [1:0]            size_sel,
   input  logic [DATA_W-1:0]     operand,
   input  logic [CNT_IN_W-1:0]   shift_cnt,
   input  logic [SHU_FLAG_W-1:0] flags_in,
   output logic [DATA_W-1:0]     result,
   output logic [SHU_FLAG_W-1:0] flags_out
);

   if (DATA_W != lane_width(SHU_NUM_LANES-1)) begin : g_bad_data
      $error("shift_flag_unit: widest lane must match the datapath");
   end

   shu_op_e             op;
   logic [CNT_BITS-1:0] cnt_eff;
   logic                cnt_zero, cnt_one;
   logic [1:0]          lane_idx;

   assign op = shu_op_e'(op_sel);

   shu_count_mask #(.CNT_IN_W(CNT_IN_W), .CNT_BITS(CNT_BITS)) u_mask (
      .cnt_raw  (shift_cnt),
      .cnt_eff  (cnt_eff),
      .cnt_zero (cnt_zero),
      .cnt_one  (cnt_one)
   );

   logic [DATA_W-1:0] lane_res  [SHU_NUM_LANES];
   shu_lane_info_t    lane_info [SHU_NUM_LANES];

   for (genvar i = 0; i < SHU_NUM_LANES; i++) begin : g_lane
      shu_lane #(
         .DATA_W   (DATA_W),
         .LANE_W   (lane_width(i)),
         .CNT_BITS (CNT_BITS)
      ) u_lane (
         .op   (op),
         .src  (operand),
         .cnt  (cnt_eff),
         .res  (lane_res[i]),
         .info (lane_info[i])
      );
   end

   // size code 3 folds onto the widest lane
   assign lane_idx = (size_sel == 2'd3) ? 2'(SHU_NUM_LANES-1) : size_sel;

   assign result = lane_res[lane_idx];

   shu_flag_gen #(.DATA_W(DATA_W)) u_flags (
      .op        (op),
      .res       (lane_res[lane_idx]),
      .info      (lane_info[lane_idx]),
      .cnt_zero  (cnt_zero),
      .cnt_one   (cnt_one),
      .flags_in  (flags_in),
      .flags_out (flags_out)
   );

   // checks across the count decoder, lanes and flag generator
   logic [DATA_W-1:0] width_mask;
   always_comb begin
      width_mask = {DATA_W{1'b1}} >> (DATA_W - lane_width(int'(lane_idx)));
   end

   always_comb begin
      p_zero_hold_r2: assert (!cnt_zero || (flags_out == flags_in &&
                              result == (operand & width_mask)))
         else $error("zero count altered state");
      p_upper_clear_r3: assert ((result & ~width_mask) == '0)
         else $error("result bits above width");
      p_ovf_keep_r6: assert (cnt_zero || cnt_one ||
                             flags_out[FL_OVF] == flags_in[FL_OVF])
         else $error("overflow changed on multi-bit shift");
      p_aux_set_r9: assert (cnt_zero || flags_out[FL_AUX])
         else $error("aux flag not set");
      p_other_pass_r10: assert ((flags_out & ~SHU_OWNED_MASK) ==
                                (flags_in & ~SHU_OWNED_MASK))
         else $error("unowned flag bit changed");
   end

endmodule

// File: tb/shift_flag_unit_test.sv
module shift_flag_unit_test;

   logic        clk = 1'b0;
   logic [1:0]  op_sel, size_sel;
   logic [31:0] operand;
   logic [7:0]  shift_cnt;
   logic [11:0] flags_in;
   logic [31:0] result;
   logic [11:0] flags_out;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   always #5 clk = ~clk;

   shift_flag_unit uut (
      .op_sel    (op_sel),
      .size_sel  (size_sel),
      .operand   (operand),
      .shift_cnt (shift_cnt),
      .flags_in  (flags_in),
      .result    (result),
      .flags_out (flags_out)
   );

   // bit-serial reference
   task automatic model(input logic [1:0] op, input logic [1:0] sz,
                        input logic [31:0] a, input logic [7:0] craw,
                        input logic [11:0] fi,
                        output logic [31:0] r, output logic [11:0] fo);
      int w;
      int c;
      logic [63:0] mask, v;
      logic cf, sgn, top, nxt;
      w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      mask = (64'd1 << w) - 64'd1;
      v    = {32'd0, a} & mask;
      c    = int'(craw) % 32;
      fo   = fi;
      cf   = 1'b0;
      sgn  = v[w-1];
      top  = v[w-1];
      nxt  = v[w-2];
      for (int i = 0; i < c; i++) begin
         if (op == 2'd2) begin
            cf = v[0];
            v  = (v >> 1) | ({63'd0, sgn} << (w-1));
         end else if (op == 2'd1) begin
            cf = v[0];
            v  = v >> 1;
         end else begin
            cf = v[w-1];
            v  = (v << 1) & mask;
         end
      end
      r = v[31:0];
      if (c != 0) begin
         fo[0] = cf;
         fo[4] = 1'b1;
         fo[6] = (v == 64'd0);
         fo[7] = v[w-1];
         fo[2] = ~^v[7:0];
         if (c == 1) begin
            if (op == 2'd2)      fo[11] = 1'b0;
            else if (op == 2'd1) fo[11] = top;
            else                 fo[11] = top ^ nxt;
         end
      end
   endtask

   task automatic check_bit(input string tag, input string what,
                            input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s op=%0d sz=%0d opnd=%h cnt=%0d got=%h exp=%h",
                  tag, what, op_sel, size_sel, operand, shift_cnt, got, exp);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [1:0] sz,
                        input logic [31:0] a, input logic [7:0] c,
                        input logic [11:0] fi);
      logic [31:0] er;
      logic [11:0] ef;
      string pre;
      @(negedge clk);
      op_sel = op; size_sel = sz; operand = a; shift_cnt = c; flags_in = fi;
      #2;
      model(op, sz, a, c, fi, er, ef);
      pre = "";
      if (c[7:5] != 3'd0) pre = {pre, "R1/"};
      if (op == 2'd3 || sz == 2'd3) pre = {pre, "R11/"};
      if (c[4:0] == 5'd0) begin
         check_bit({pre, "R2"}, "result", result, er);
         check_bit({pre, "R2"}, "flags", {20'd0, flags_out}, {20'd0, ef});
      end else begin
         check_bit({pre, "R3"}, "result", result, er);
         check_bit({pre, "R4"}, "CF", {31'd0, flags_out[0]}, {31'd0, ef[0]});
         check_bit({pre, (c[4:0] == 5'd1) ? "R5" : "R6"}, "OF",
                   {31'd0, flags_out[11]}, {31'd0, ef[11]});
         check_bit({pre, "R7"}, "ZF/SF", {30'd0, flags_out[7:6]}, {30'd0, ef[7:6]});
         check_bit({pre, "R8"}, "PF", {31'd0, flags_out[2]}, {31'd0, ef[2]});
         check_bit({pre, "R9"}, "AF", {31'd0, flags_out[4]}, {31'd0, ef[4]});
      end
      // R10: flag bits not owned by the shifter
      check_bit({pre, "R10"}, "other flags", {20'd0, flags_out & 12'h72A},
                {20'd0, fi & 12'h72A});
   endtask

   logic [31:0] pats [4] = '{32'h8000_0081, 32'h4000_4001, 32'hFFFF_FF7F, 32'h00C3_5A96};
   logic [7:0]  cnts [14] = '{8'd0, 8'd1, 8'd2, 8'd7, 8'd8, 8'd9, 8'd15,
                              8'd16, 8'd17, 8'd31, 8'd32, 8'd33, 8'd255, 8'd40};

   initial begin
      op_sel = 0; size_sel = 0; operand = 0; shift_cnt = 0; flags_in = 0;
      // idle state: all-zero inputs give zero outputs (R2)
      #3;
      check_bit("R2", "idle result", result, 32'd0);
      check_bit("R2", "idle flags", {20'd0, flags_out}, 32'd0);
      // directed sweep over every code, count boundary and pattern
      for (int op = 0; op < 4; op++)
         for (int sz = 0; sz < 4; sz++)
            for (int p = 0; p < 4; p++)
               for (int k = 0; k < 14; k++)
                  apply(2'(op), 2'(sz), pats[p], cnts[k],
                        (k % 2 == 0) ? 12'hFFF : 12'h000);
      // R5: explicit single-bit overflow cases
      apply(2'd0, 2'd0, 32'h0000_0040, 8'd1, 12'h000); // left 0x40: OF=1
      apply(2'd1, 2'd1, 32'h0000_8000, 8'd1, 12'h000); // logical right: OF=top
      apply(2'd2, 2'd2, 32'h8000_0000, 8'd1, 12'h800); // arithmetic: OF=0
      // random traffic
      for (int n = 0; n < 1500; n++)
         apply(2'($urandom), 2'($urandom), $urandom, 8'($urandom),
               12'($urandom));
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule